// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request issued by a 32-lane warp and turns it into the smallest set of aligned 128-byte line transfers that covers the request. Each lane brings a byte address, and a lane mask says which lanes take part. An element size in bytes says how much data each active lane needs. The block groups active lanes by the 128-byte line that holds their address. It then sends one transaction per distinct line, one after another, over a valid/ready handshake. Each transaction carries the aligned line address and the mask of lanes that the line serves.

When all transactions for a request have been handed off, the block reports the request's totals for one cycle: the number of transactions, the bytes the active lanes need, and the bytes moved in whole lines. From these totals access efficiency can be computed as needed over moved. A contiguous, line-aligned warp of 4-byte elements therefore costs one line. A warp whose lanes are 128 bytes apart costs 32 lines for the same 128 bytes of demand.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, and txn_valid and done_valid are both 0.
- R2: A transaction's line address is the byte address of its lanes with bits [6:0] cleared, so bits [6:0] of txn_line are always 0.
- R3: One transaction is issued per distinct 128-byte line touched by active lanes. No lane appears in two transactions of a request. 32 contiguous, line-aligned 4-byte elements give exactly one transaction whose lane mask is all ones.
- R4: When consecutive active lanes are 128 bytes apart, each lane gets its own line, so a full warp yields 32 transactions, each with exactly one lane bit set.
- R5: Transactions come out in order of the lowest-numbered unserved active lane. Each transaction's lane mask (bit i = lane i) holds every unserved active lane whose address falls in the same line.
- R6: Lanes whose mask bit is 0 are ignored. Their addresses create no transaction, and they never appear in a transaction lane mask.
- R7: A request with an all-zero lane mask produces no transaction. done_valid rises in the cycle after acceptance, with all three totals equal to 0.
- R8: While txn_valid is 1 and txn_ready is 0, txn_valid, txn_line and txn_lanes hold their values into the next cycle.
- R9: req_ready is 0 from acceptance until the cycle after the done report. A new request is taken only after the last transaction of the previous one has been handed off.
- R10: In the done cycle, done_txns equals the number of transactions handed off, done_bytes_needed equals the count of active lanes times req_elem_bytes, and done_bytes_moved equals done_txns times 128.
- R11: txn_last is 1 exactly on the final transaction of a request, and done_valid follows in the cycle after that transaction is handed off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addrs | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_lanes | input | LANES | Active-lane mask, bit i = lane i |
| req_elem_bytes | input | ESZ_W | Element size in bytes |
| txn_valid | output | 1 | Line transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | ADDR_W | Aligned line address |
| txn_lanes | output | LANES | Lanes served by this line |
| txn_last | output | 1 | Final transaction of the request |
| done_valid | output | 1 | One-cycle request completion report |
| done_txns | output | CNT_W | Transactions issued for the request |
| done_bytes_needed | output | CNT_W+ESZ_W | Active lanes times element size |
| done_bytes_moved | output | CNT_W+OFF_W | Transactions times line size |

## Verification
The grouping logic is tried with several address patterns, and each one separates different faults. A contiguous aligned warp and a broadcast to one address must collapse to a single line. A 128-byte stride must expand to one line per lane. A misaligned contiguous warp and 8-byte elements must split at the right lane. Two lines interleaved lane by lane expose any grouping of adjacent lanes instead of lanes that share a line. A descending stride shows that lane order, not address order, sets the emission order. Partial and sparse masks, a single active lane among scattered addresses, and an empty mask show that inactive lanes are ignored, and that the totals and the byte demand follow the mask and element size rather than the pattern. Several of these runs stall the output with a toggling ready, to show that the transaction sequence does not depend on downstream pacing.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic {
    WC_IDLE = 1'b0,
    WC_BUSY = 1'b1
  } wc_state_e;

  // bytes moved for n whole lines of 2**off_w bytes
  function automatic int unsigned wc_line_bytes(int unsigned n, int unsigned off_w);
    return n << off_w;
  endfunction

  // bytes demanded by the active lanes
  function automatic int unsigned wc_demand(int unsigned lanes_on, int unsigned esz);
    return lanes_on * esz;
  endfunction

endpackage

// File: rtl/wc_first_lane.sv
module wc_first_lane #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // lowest-numbered pending lane wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/wc_line_match.sv
module wc_line_match #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES*ADDR_W-1:0] addrs,
  input  logic [LANES-1:0]        pend,
  input  logic [IDX_W-1:0]        sel_idx,
  output logic [ADDR_W-1:0]       sel_line,
  output logic [LANES-1:0]        match
);

  logic [ADDR_W-1:0] sel_addr;

  assign sel_addr = addrs[sel_idx*ADDR_W +: ADDR_W];
  assign sel_line = {sel_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-OFF_W-1:0] tag;
    assign tag      = addrs[g*ADDR_W+OFF_W +: ADDR_W-OFF_W];
    assign match[g] = pend[g] && (tag == sel_addr[ADDR_W-1:OFF_W]);
  end

endmodule

// File: rtl/wc_tally.sv
module wc_tally #(
  parameter int LANES = 32,
  parameter int ESZ_W = 4,
  parameter int OFF_W = 7,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LANES-1:0]       start_lanes,
  input  logic [ESZ_W-1:0]       start_esz,
  input  logic                   step,
  output logic [CNT_W-1:0]       txns,
  output logic [CNT_W+ESZ_W-1:0] need,
  output logic [CNT_W+OFF_W-1:0] moved
);

  function automatic int unsigned count_on(logic [LANES-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < LANES; i++) n += int'(v[i]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txns <= '0;
      need <= '0;
    end else if (start) begin
      txns <= '0;
      need <= (CNT_W+ESZ_W)'(wc_pkg::wc_demand(count_on(start_lanes), int'(start_esz)));
    end else if (step) begin
      txns <= txns + 1'b1;
    end
  end

  assign moved = (CNT_W+OFF_W)'(wc_pkg::wc_line_bytes(int'(txns), OFF_W));

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int ESZ_W      = 4,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addrs,
  input  logic [LANES-1:0]        req_lanes,
  input  logic [ESZ_W-1:0]        req_elem_bytes,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_line,
  output logic [LANES-1:0]        txn_lanes,
  output logic                    txn_last,
  output logic                    done_valid,
  output logic [CNT_W-1:0]        done_txns,
  output logic [CNT_W+ESZ_W-1:0]  done_bytes_needed,
  output logic [CNT_W+OFF_W-1:0]  done_bytes_moved
);

  wc_pkg::wc_state_e state_q;

  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend_q;
  logic                    have_lane;
  logic [IDX_W-1:0]        first_idx;
  logic [LANES-1:0]        same_line;
  logic [LANES-1:0]        pend_after;

  // named events used by the checker
  wire busy       = (state_q == wc_pkg::WC_BUSY);
  wire req_accept = req_valid && req_ready;
  wire txn_fire   = txn_valid && txn_ready;

  wc_first_lane #(.LANES(LANES)) u_first (
    .pend  (pend_q),
    .found (have_lane),
    .idx   (first_idx)
  );

  wc_line_match #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .addrs    (addr_q),
    .pend     (pend_q),
    .sel_idx  (first_idx),
    .sel_line (txn_line),
    .match    (same_line)
  );

  wc_tally #(.LANES(LANES), .ESZ_W(ESZ_W), .OFF_W(OFF_W)) u_tally (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (req_accept),
    .start_lanes (req_lanes),
    .start_esz   (req_elem_bytes),
    .step        (txn_fire),
    .txns        (done_txns),
    .need        (done_bytes_needed),
    .moved       (done_bytes_moved)
  );

  assign pend_after = pend_q & ~same_line;
  assign req_ready  = !busy;
  assign txn_valid  = busy && have_lane;
  assign txn_lanes  = same_line;
  assign txn_last   = (pend_after == '0);
  assign done_valid = busy && !have_lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= wc_pkg::WC_IDLE;
      addr_q  <= '0;
      pend_q  <= '0;
    end else begin
      if (req_accept) begin
        state_q <= wc_pkg::WC_BUSY;
        addr_q  <= req_addrs;
        pend_q  <= req_lanes;
      end else if (txn_fire) begin
        pend_q  <= pend_after;
      end else if (done_valid) begin
        state_q <= wc_pkg::WC_IDLE;
      end
    end
  end

endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_lanes,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic              txn_fire,
  input logic [ADDR_W-1:0] txn_line,
  input logic [LANES-1:0]  txn_lanes,
  input logic              txn_last,
  input logic              done_valid,
  input logic [CNT_W-1:0]  done_txns
);

  logic [LANES-1:0] seen_lanes;
  logic [LANES-1:0] served;
  logic [CNT_W-1:0] fired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_lanes <= '0;
      served     <= '0;
      fired      <= '0;
    end else if (req_valid && req_ready) begin
      seen_lanes <= req_lanes;
      served     <= '0;
      fired      <= '0;
    end else if (txn_fire) begin
      served     <= served | txn_lanes;
      fired      <= fired + 1'b1;
    end
  end

  // R8
  txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_line) && $stable(txn_lanes));

  // R2
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_line[OFF_W-1:0] == '0);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid || done_valid) |-> !req_ready);

  // R11
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire && txn_last |=> done_valid);

  // R3
  disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (served & txn_lanes) == '0 && txn_lanes != '0);

  // R6
  active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes & ~seen_lanes) == '0);

  // R10
  txn_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_txns == fired);

endmodule

bind warp_coalescer wc_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
) u_wc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_lanes  (req_lanes),
  .txn_valid  (txn_valid),
  .txn_ready  (txn_ready),
  .txn_fire   (txn_fire),
  .txn_line   (txn_line),
  .txn_lanes  (txn_lanes),
  .txn_last   (txn_last),
  .done_valid (done_valid),
  .done_txns  (done_txns)
);

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int NVEC  = 7;

  // table: base, stride, mask, element bytes, expected transactions, stall
  localparam int unsigned V_BASE[NVEC]   = '{32'h1000, 32'h2000, 32'h3040, 32'h0100, 32'h0000, 32'h4000, 32'h0010};
  localparam int          V_STRIDE[NVEC] = '{4, 128, 4, 8, 4, 0, 64};
  localparam int unsigned V_MASK[NVEC]   = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                             32'h0000FFFF, 32'hFFFFFFFF, 32'hAAAAAAAA};
  localparam int unsigned V_ESZ[NVEC]    = '{4, 4, 4, 8, 4, 2, 4};
  localparam int unsigned V_NTX[NVEC]    = '{1, 32, 2, 2, 1, 1, 16};
  localparam bit          V_STALL[NVEC]  = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES*AW-1:0] req_addrs = '0;
  logic [LANES-1:0] req_lanes = '0;
  logic [3:0] req_elem_bytes = '0;
  logic txn_valid;
  logic txn_ready = 1'b1;
  logic [AW-1:0] txn_line;
  logic [LANES-1:0] txn_lanes;
  logic txn_last;
  logic done_valid;
  logic [5:0] done_txns;
  logic [9:0] done_bytes_needed;
  logic [12:0] done_bytes_moved;

  int checks = 0;
  int failures = 0;

  logic [AW-1:0]    exp_line[32];
  logic [LANES-1:0] exp_mask[32];
  int               exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer i_warp_coalescer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addrs(req_addrs),
    .req_lanes(req_lanes), .req_elem_bytes(req_elem_bytes),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_line(txn_line),
    .txn_lanes(txn_lanes), .txn_last(txn_last),
    .done_valid(done_valid), .done_txns(done_txns),
    .done_bytes_needed(done_bytes_needed), .done_bytes_moved(done_bytes_moved)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference grouping: scan lanes in order, open a line at each unserved active lane
  task automatic build_expect(input logic [LANES*AW-1:0] a, input logic [LANES-1:0] m);
    logic [LANES-1:0] done_l = '0;
    exp_n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (m[i] && !done_l[i]) begin
        logic [AW-1:0] ln = a[i*AW +: AW] & ~32'h7F;
        logic [LANES-1:0] grp = '0;
        for (int j = 0; j < LANES; j++)
          if (m[j] && ((a[j*AW +: AW] & ~32'h7F) == ln)) grp[j] = 1'b1;
        done_l |= grp;
        exp_line[exp_n] = ln;
        exp_mask[exp_n] = grp;
        exp_n++;
      end
    end
  endtask

  task automatic run_req(input logic [LANES*AW-1:0] a, input logic [LANES-1:0] m,
                         input logic [3:0] esz, input int ntx, input bit stall, input string tag);
    int k = 0;
    int cyc = 0;
    bit finished = 0;
    build_expect(a, m);
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R9 ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_addrs = a; req_lanes = m; req_elem_bytes = esz;
    txn_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!finished && cyc < 400) begin
      if (done_valid) begin
        check(done_txns == 6'(ntx), {tag, " R3/R4 transaction count"}, done_txns, ntx);
        check(done_bytes_needed == 10'($countones(m) * esz), {tag, " R10 bytes needed"},
              done_bytes_needed, $countones(m) * esz);
        check(done_bytes_moved == 13'(ntx * 128), {tag, " R10 bytes moved"}, done_bytes_moved, ntx * 128);
        check(k == exp_n, {tag, " R11 done after last"}, k, exp_n);
        finished = 1;
      end else if (txn_valid) begin
        check(req_ready == 1'b0, {tag, " R9 busy"}, req_ready, 0);
        if (txn_ready) begin
          if (k < exp_n) begin
            check(txn_line == exp_line[k], {tag, " R2/R5 line"}, txn_line, exp_line[k]);
            check(txn_lanes == exp_mask[k], {tag, " R5/R6 lanes"}, txn_lanes, exp_mask[k]);
            check(txn_last == (k == exp_n - 1), {tag, " R11 last flag"}, txn_last, k == exp_n - 1);
          end
          k++;
        end
      end
      txn_ready = stall ? cyc[0] : 1'b1;
      cyc++;
      @(negedge clk);
    end
    check(finished, {tag, " R9 request completes"}, finished, 1);
    txn_ready = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [LANES*AW-1:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(txn_valid == 1'b0, "R1 txn_valid", txn_valid, 0);
    check(done_valid == 1'b0, "R1 done_valid", done_valid, 0);

    // table walk: R3 contiguous, R4 stride 128, misaligned, wide elements, partial mask, broadcast, sparse
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < LANES; i++) a[i*AW +: AW] = V_BASE[v] + 32'(i * V_STRIDE[v]);
      run_req(a, V_MASK[v], 4'(V_ESZ[v]), V_NTX[v], V_STALL[v], $sformatf("vec%0d", v));
    end

    // R4 one lane per line, single-bit masks in lane order
    for (int i = 0; i < LANES; i++) a[i*AW +: AW] = 32'h2000 + 32'(i * 128);
    build_expect(a, '1);
    check(exp_mask[31] == 32'h80000000 && exp_line[31] == 32'h2F80, "R4 model sanity",
          exp_line[31], 32'h2F80);

    // R5 interleaved lines: first 0x8000 with even lanes, then 0x9000 with odd lanes, stalled
    for (int i = 0; i < LANES; i++) a[i*AW +: AW] = ((i % 2) ? 32'h9000 : 32'h8000) + 32'(i * 4);
    run_req(a, '1, 4'd4, 2, 1'b1, "interleave R5");

    // R5 descending addresses still emitted in lane order
    for (int i = 0; i < LANES; i++) a[i*AW +: AW] = 32'h5000 - 32'(i * 128);
    run_req(a, '1, 4'd4, 32, 1'b1, "descending R5");

    // R6 only lane 5 active among scattered lines
    for (int i = 0; i < LANES; i++) a[i*AW +: AW] = 32'h6000 + 32'(i * 128) + 32'd12;
    run_req(a, 32'h00000020, 4'd4, 1, 1'b0, "single lane R6");

    // R7 empty mask: done next cycle, zero totals
    @(negedge clk);
    req_valid = 1'b1; req_lanes = '0; req_elem_bytes = 4'd4;
    @(negedge clk);
    req_valid = 1'b0;
    check(txn_valid == 1'b0, "R7 no transaction", txn_valid, 0);
    check(done_valid == 1'b1, "R7 done next cycle", done_valid, 1);
    check(done_txns == 0 && done_bytes_needed == 0 && done_bytes_moved == 0, "R7 zero totals",
          done_bytes_moved, 0);
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after done", req_ready, 1);
    check(done_valid == 1'b0, "R7 done is one cycle", done_valid, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule